// File: doc/BRIEF.md
# SCSI Controller Command Decoder and Interrupt Status

This block sits behind the host register port of a SCSI-style bus controller. It watches byte writes to the command offset, decodes the seven-bit command code, and updates four status-side registers: the phase/status register, the interrupt cause register, the sequence-step register and the FIFO-flags register. It also owns a writable configuration register, a read-only chip identification value and the interrupt line. The bus selection itself, the data FIFO and the DMA datapath live elsewhere. The only thing this block learns about a selection is a single level input, `sel_target_ok`, which says whether the addressed target answered.

The host reads registers through a combinational read port. A read of the interrupt cause register is destructive. The host sees the old value, and at the same clock edge the block clears the cause, clears the terminal-count bit, sets the sequence step to 4 and drops the interrupt. Command writes that decode to no known code change nothing and pulse `cmd_err` for one cycle. All ports are plain control and status pins. The block has no streaming interface and so no back-pressure.

Top module: `scsi_cmd_status`

## Requirements
- R1: After reset, the register offsets read as follows: status (offset 4) 0x00, interrupt cause (5) 0x00, sequence step (6) 0x00, flags (7) 0x00, configuration (8) 0x07 and chip ID (14) 0x04. The `irq` output is low.
- R2: Any command that raises the interrupt sets status bit 7 and drives `irq` high. `irq` always equals status bit 7, and it stays high until it is explicitly lowered.
- R3: A read of offset 5 returns the cause value held before the read. From the next cycle the cause is 0x00, status bits 7 and 4 are clear, the sequence step is 4 and `irq` is low.
- R4: Command code 0x01 (flush) sets the cause to 0x08 and clears both the sequence step and the flags. It leaves the status register and `irq` unchanged.
- R5: Command code 0x02 (chip reset) returns every register to its R1 value and lowers `irq`.
- R6: Command code 0x03 (bus reset) sets the cause to 0x80. It raises the interrupt only when configuration bit 6 is 0.
- R7: Command code 0x10 (transfer info) clears status bit 4 and changes nothing else.
- R8: Command code 0x11 (initiator complete) does the following and raises the interrupt:
  - sets status bit 4 and status bits 2:0 to 3'b111;
  - sets the flags to 0x02;
  - sets the cause to 0x08.
- R9: Command code 0x12 (message accept) sets the cause to 0x20, clears the sequence step and the flags, and raises the interrupt.
- R10: Command code 0x18 (pad) sets status bits 6:0 to 0x10, the cause to 0x08 and the sequence step to 0. It leaves status bit 7 and `irq` unchanged.
- R11: Command codes 0x41, 0x42 and 0x43 (select variants) always raise the interrupt. Command byte bit 7 plays no part in decoding any command.
  - If `sel_target_ok` is 1, they set status bit 4, the cause to 0x18 and the sequence step to 4.
  - Otherwise they set status bits 6:0 to 0, the cause to 0x20 and the sequence step to 0.
- R12: Command code 0x44 (enable selection) clears the cause. Codes 0x00 (no-op) and 0x1A (set attention) change no register.
- R13: Any other command code changes no register and drives `cmd_err` high for exactly the cycle after the write.
- R14: Writes to offset 8 load the configuration register. Writes to offsets other than 3 and 8 have no effect. Reads of offsets other than 4 to 8 and 14 return 0x00, and `rd_data` is 0x00 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 4 | Host write offset |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host byte read strobe; a read of offset 5 is destructive |
| rd_addr | input | 4 | Host read offset |
| rd_data | output | 8 | Read byte, combinational from the current register values |
| sel_target_ok | input | 1 | Level: the addressed target answered selection |
| irq | output | 1 | Interrupt request, equal to status bit 7 |
| cmd_err | output | 1 | One-cycle pulse after an unrecognised command |

## Verification
The assertions assume that the host never writes and reads in the same cycle. This matters because a destructive cause read and a command write could otherwise both update the cause register at one edge. The assertions also assume that `sel_target_ok` is steady during any cycle that carries a select command. The bench uses tasks that issue exactly one access per cycle and set `sel_target_ok` before the access starts, so the stimulus always stays within these conditions.

// File: rtl/scsi_cs_pkg.sv
`timescale 1ns/1ps
package scsi_cs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 4;

  // register offsets the host map decodes
  localparam logic [ADDR_W-1:0] OFS_CMD   = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_STEP  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_FLAGS = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_ID    = 4'hE;

  // status bit positions
  localparam int unsigned ST_IRQ = 7;
  localparam int unsigned ST_TC  = 4;

  // interrupt cause values
  localparam logic [BYTE_W-1:0] CAUSE_DONE  = 8'h08;
  localparam logic [BYTE_W-1:0] CAUSE_BUSSV = 8'h10;
  localparam logic [BYTE_W-1:0] CAUSE_DISC  = 8'h20;
  localparam logic [BYTE_W-1:0] CAUSE_BRST  = 8'h80;
  localparam logic [BYTE_W-1:0] STEP_DONE   = 8'h04;

  typedef enum logic [3:0] {
    OP_NONE, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_ICMPL,
    OP_MSGACC, OP_PAD, OP_SELECT, OP_ENSEL, OP_BAD
  } op_e;
endpackage

// File: rtl/scsi_cs_decode.sv
`timescale 1ns/1ps
module scsi_cs_decode
  import scsi_cs_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [6:0]        code,
  output op_e               op
);
  always_comb begin
    op = OP_NONE;
    if (wr_en && (wr_addr == OFS_CMD)) begin
      case (code)
        7'h00, 7'h1A:        op = OP_NONE;
        7'h01:               op = OP_FLUSH;
        7'h02:               op = OP_CHIPRST;
        7'h03:               op = OP_BUSRST;
        7'h10:               op = OP_XFER;
        7'h11:               op = OP_ICMPL;
        7'h12:               op = OP_MSGACC;
        7'h18:               op = OP_PAD;
        7'h41, 7'h42, 7'h43: op = OP_SELECT;
        7'h44:               op = OP_ENSEL;
        default:             op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/scsi_cs_regs.sv
`timescale 1ns/1ps
module scsi_cs_regs
  import scsi_cs_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST = 8'h07,
  parameter int unsigned       RPT_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              sel_ok,
  input  logic              cause_rd,
  input  logic              cfg_we,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] cause_q,
  output logic [BYTE_W-1:0] step_q,
  output logic [BYTE_W-1:0] flags_q,
  output logic [BYTE_W-1:0] cfg_q,
  output logic              err_q
);
  logic [BYTE_W-1:0] stat_n, cause_n, step_n, flags_n, cfg_n;
  logic              raise;

  always_comb begin
    stat_n  = stat_q;
    cause_n = cause_q;
    step_n  = step_q;
    flags_n = flags_q;
    cfg_n   = cfg_q;
    raise   = 1'b0;
    if (cause_rd) begin
      cause_n        = '0;
      stat_n[ST_TC]  = 1'b0;
      stat_n[ST_IRQ] = 1'b0;
      step_n         = STEP_DONE;
    end
    case (op)
      OP_FLUSH: begin
        cause_n = CAUSE_DONE;
        step_n  = '0;
        flags_n = '0;
      end
      OP_CHIPRST: begin
        stat_n  = '0;
        cause_n = '0;
        step_n  = '0;
        flags_n = '0;
        cfg_n   = CFG_RST;
      end
      OP_BUSRST: begin
        cause_n = CAUSE_BRST;
        raise   = ~cfg_q[RPT_BIT];
      end
      OP_XFER: stat_n[ST_TC] = 1'b0;
      OP_ICMPL: begin
        stat_n[ST_TC] = 1'b1;
        stat_n[2:0]   = 3'b111;
        flags_n       = 8'h02;
        cause_n       = CAUSE_DONE;
        raise         = 1'b1;
      end
      OP_MSGACC: begin
        cause_n = CAUSE_DISC;
        step_n  = '0;
        flags_n = '0;
        raise   = 1'b1;
      end
      OP_PAD: begin
        stat_n  = {stat_q[ST_IRQ], 7'h10};
        cause_n = CAUSE_DONE;
        step_n  = '0;
      end
      OP_SELECT: begin
        raise = 1'b1;
        if (sel_ok) begin
          stat_n[ST_TC] = 1'b1;
          cause_n       = CAUSE_BUSSV | CAUSE_DONE;
          step_n        = STEP_DONE;
        end else begin
          stat_n  = {stat_q[ST_IRQ], 7'h00};
          cause_n = CAUSE_DISC;
          step_n  = '0;
        end
      end
      OP_ENSEL: cause_n = '0;
      default: ;
    endcase
    if (cfg_we) cfg_n = cfg_wdata;
    if (raise)  stat_n[ST_IRQ] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      cause_q <= '0;
      step_q  <= '0;
      flags_q <= '0;
      cfg_q   <= CFG_RST;
      err_q   <= 1'b0;
    end else begin
      stat_q  <= stat_n;
      cause_q <= cause_n;
      step_q  <= step_n;
      flags_q <= flags_n;
      cfg_q   <= cfg_n;
      err_q   <= (op == OP_BAD);
    end
  end
endmodule

// File: rtl/scsi_cs_rdmux.sv
`timescale 1ns/1ps
module scsi_cs_rdmux
  import scsi_cs_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'h04
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] stat,
  input  logic [BYTE_W-1:0] cause,
  input  logic [BYTE_W-1:0] step,
  input  logic [BYTE_W-1:0] flags,
  input  logic [BYTE_W-1:0] cfg,
  output logic [BYTE_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        OFS_STAT:  rd_data = stat;
        OFS_CAUSE: rd_data = cause;
        OFS_STEP:  rd_data = step;
        OFS_FLAGS: rd_data = flags;
        OFS_CFG:   rd_data = cfg;
        OFS_ID:    rd_data = CHIP_ID;
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/scsi_cmd_status.sv
`timescale 1ns/1ps
module scsi_cmd_status
  import scsi_cs_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h04,
  parameter logic [7:0] CFG_RST = 8'h07,
  parameter int unsigned RPT_BIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sel_target_ok,
  output logic       irq,
  output logic       cmd_err
);
  op_e               op;
  logic [BYTE_W-1:0] stat_q, cause_q, step_q, flags_q, cfg_q;
  logic              cause_rd, cfg_we;

  assign cause_rd = rd_en && (rd_addr == OFS_CAUSE);
  assign cfg_we   = wr_en && (wr_addr == OFS_CFG);

  scsi_cs_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .code    (wr_data[6:0]),
    .op      (op)
  );

  scsi_cs_regs #(.CFG_RST(CFG_RST), .RPT_BIT(RPT_BIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .sel_ok    (sel_target_ok),
    .cause_rd  (cause_rd),
    .cfg_we    (cfg_we),
    .cfg_wdata (wr_data),
    .stat_q    (stat_q),
    .cause_q   (cause_q),
    .step_q    (step_q),
    .flags_q   (flags_q),
    .cfg_q     (cfg_q),
    .err_q     (cmd_err)
  );

  scsi_cs_rdmux #(.CHIP_ID(CHIP_ID)) u_rd (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .stat    (stat_q),
    .cause   (cause_q),
    .step    (step_q),
    .flags   (flags_q),
    .cfg     (cfg_q),
    .rd_data (rd_data)
  );

  assign irq = stat_q[ST_IRQ];
endmodule

// File: rtl/scsi_cmd_status_chk.sv
`timescale 1ns/1ps
module scsi_cmd_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [6:0] code,
  input logic       rd_en,
  input logic [3:0] rd_addr,
  input logic       irq,
  input logic       cmd_err,
  input logic [7:0] stat,
  input logic [7:0] cause,
  input logic [7:0] step,
  input logic [7:0] cfg
);
  logic is_cmd;
  assign is_cmd = wr_en && (wr_addr == 4'h3);

  a_r3_cause_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'h5 && !wr_en) |=> (cause == 8'h00 && step == 8'h04 && !irq && !stat[4]));

  a_r9_msgacc_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && code == 7'h12) |=> irq);

  a_r6_busrst_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && code == 7'h03 && cfg[6] && !irq && !rd_en) |=> !irq);

  a_r10_pad_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && code == 7'h18 && !rd_en) |=> (irq == $past(irq)));

  a_r5_chip_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && code == 7'h02) |=> (!irq && cfg == 8'h07 && cause == 8'h00));

  a_r13_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (stat == $past(stat) && cause == $past(cause) &&
                 step == $past(step) && cfg == $past(cfg)));
endmodule

bind scsi_cmd_status scsi_cmd_status_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .code    (wr_data[6:0]),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .irq     (irq),
  .cmd_err (cmd_err),
  .stat    (stat_q),
  .cause   (cause_q),
  .step    (step_q),
  .cfg     (cfg_q)
);

// File: tb/scsi_cmd_status_tb.sv
`timescale 1ns/1ps
module scsi_cmd_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sel_target_ok = 1'b0;
  logic       irq, cmd_err;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int m_st = 0, m_ca = 0, m_sq = 0, m_fl = 0, m_cf = 7, m_err = 0;

  always #4 clk = ~clk;

  scsi_cmd_status u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sel_target_ok(sel_target_ok), .irq(irq), .cmd_err(cmd_err)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // compared on every clock: R2 irq tracks the model's status bit 7, R13 error pulse
  always @(negedge clk) if (live && !done) begin
    check("R2 irq line", int'(irq), (m_st >> 7) & 1);
    check("R13 cmd_err", int'(cmd_err), m_err);
  end

  function automatic int m_read(int a);
    case (a)
      4: return m_st;
      5: return m_ca;
      6: return m_sq;
      7: return m_fl;
      8: return m_cf;
      14: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic m_command(int c, bit ok);
    int code = c & 'h7F;
    bit up = 0;
    m_err = 0;
    if (code == 'h00 || code == 'h1A) begin end
    else if (code == 'h01) begin m_ca = 'h08; m_sq = 0; m_fl = 0; end
    else if (code == 'h02) begin m_st = 0; m_ca = 0; m_sq = 0; m_fl = 0; m_cf = 7; end
    else if (code == 'h03) begin m_ca = 'h80; up = ((m_cf & 'h40) == 0); end
    else if (code == 'h10) m_st = m_st & ~'h10;
    else if (code == 'h11) begin m_st = m_st | 'h17; m_fl = 2; m_ca = 'h08; up = 1; end
    else if (code == 'h12) begin m_ca = 'h20; m_sq = 0; m_fl = 0; up = 1; end
    else if (code == 'h18) begin m_st = (m_st & 'h80) | 'h10; m_ca = 'h08; m_sq = 0; end
    else if (code >= 'h41 && code <= 'h43) begin
      up = 1;
      if (ok) begin m_st = m_st | 'h10; m_ca = 'h18; m_sq = 4; end
      else begin m_st = m_st & 'h80; m_ca = 'h20; m_sq = 0; end
    end
    else if (code == 'h44) m_ca = 0;
    else m_err = 1;
    if (up) m_st = m_st | 'h80;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a == 3) m_command(d, sel_target_ok);
    else begin
      m_err = 0;
      if (a == 8) m_cf = d & 'hFF;
    end
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 4'(a);
    #1 check(tag, int'(rd_data), m_read(a));
    @(posedge clk); #1;
    rd_en = 1'b0;
    m_err = 0;
    if (a == 5) begin m_ca = 0; m_st = m_st & ~'h90; m_sq = 4; end
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk); #1;
    m_err = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    live = 1'b1;
    // R1 reset values
    rd(4, "R1 status"); rd(5, "R1 cause"); rd(6, "R1 step"); rd(7, "R1 flags");
    rd(8, "R1 config"); rd(14, "R1 chip id");
    check("R1 irq low", int'(irq), 0);
    // R14 unmapped read / write ignored, read strobe low gives zero
    rd(0, "R14 unmapped read");
    wr(0, 'hFF); wr(6, 'h55); rd(6, "R14 write to step ignored"); rd(0, "R14 offset 0");
    #1 check("R14 idle rd_data", int'(rd_data), 0);
    // R9 message accept, then R3 destructive read
    wr(3, 'h12);
    rd(4, "R9 status after msg accept"); rd(7, "R9 flags");
    rd(5, "R3 cause returns old value"); rd(5, "R3 cause cleared");
    rd(6, "R3 step forced"); rd(4, "R3 status cleared");
    // R4 flush
    wr(3, 'h01); rd(5, "R4 flush cause"); rd(6, "R4 flush step"); rd(7, "R4 flush flags");
    // R6 bus reset, unmasked then masked
    wr(3, 'h03); idle(); rd(5, "R6 bus reset cause");
    wr(8, 'h47); rd(8, "R14 config write");
    wr(3, 'h03); idle(); rd(4, "R6 masked status"); rd(5, "R6 masked cause");
    // R11 select with target present
    sel_target_ok = 1'b1;
    wr(3, 'h42); rd(4, "R11 select ok status"); rd(6, "R11 select ok step");
    rd(5, "R11 select ok cause");
    // R11 missing target with command bit 7 set
    sel_target_ok = 1'b0;
    wr(3, 'hC1); rd(4, "R11 missing status"); rd(6, "R11 missing step"); rd(5, "R11 missing cause");
    sel_target_ok = 1'b1;
    wr(3, 'h43);
    // R7 transfer info clears bit 4 only
    wr(3, 'h10); rd(4, "R7 status after transfer"); rd(6, "R7 step kept");
    // R8 initiator complete
    wr(3, 'h11); rd(4, "R8 status"); rd(7, "R8 flags"); rd(5, "R8 cause");
    // R10 pad with irq high, then low
    wr(3, 'h03); wr(8, 'h07); wr(3, 'h03);
    wr(3, 'h18); rd(4, "R10 pad keeps irq"); rd(5, "R10 pad cause");
    wr(3, 'h18); rd(4, "R10 pad status irq low"); rd(6, "R10 pad step");
    // R12 enable selection, no-op, set attention
    wr(3, 'h12); wr(3, 'h44); rd(5, "R12 enable selection cause");
    wr(3, 'h12); wr(3, 'h00); wr(3, 'h1A); wr(3, 'h80);
    rd(4, "R12 nop status"); rd(6, "R12 nop step"); rd(5, "R12 nop cause");
    // R13 unknown commands
    wr(3, 'h05); idle(); wr(3, 'h7F); wr(3, 'h20);
    rd(4, "R13 status unchanged"); rd(6, "R13 step unchanged");
    // R5 chip reset
    wr(8, 'h6A); wr(3, 'h11); wr(3, 'h82);
    rd(4, "R5 status"); rd(5, "R5 cause"); rd(6, "R5 step"); rd(7, "R5 flags");
    rd(8, "R5 config"); rd(14, "R5 chip id");
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule